// File: doc/BRIEF.md
# Synchronising Register File with Dataflow States

This block is a small register file whose entries act as single-assignment synchronisers between threads. Each entry holds a data word and a two-bit state tag. When an entry is not full, its data field holds a continuation: the table index of a local thread that is waiting, or the register address of a remote requester. A pipeline read of an entry that is not full never stalls. The read returns with its valid flag low, and the entry records the reader. The later data write fills the entry and produces either a reschedule event for the stored thread or a reply event for the remote requester.

There are three ports:
- A pipeline read port, with a combinational result in the same cycle.
- A pipeline writeback port. It can write data, or it can clear a full entry to empty so that a late result can fill it later (a load miss or a variable-latency operation).
- An asynchronous write port for those late results.

If the writeback and the asynchronous port target the same entry in one cycle, the asynchronous write waits one cycle in a holding register. Its ready output is low while that register is occupied. The thread scheduler, the ring network and any cache are outside this block; wake-up and reply events leave it as outputs.

Top module: `sync_regfile`

## Requirements
- R1: After reset every entry is empty (state code 0) and `aw_ready_o` is high.
- R2: A local read (`rd_remote_i`=0) of an empty entry returns `rd_valid_o`=0. The entry moves to waiting-local (code 2) and stores `rd_tid_i` in its data field.
- R3: A remote read (`rd_remote_i`=1) of an empty entry returns `rd_valid_o`=0. The entry moves to waiting-remote (code 3) and stores `rd_raddr_i` in its data field.
- R4: A data write to a waiting-local entry makes it full (code 1). In the same cycle it raises the wake bit of its port with the stored thread index. Bit 0 of each event bus belongs to the writeback port and bit 1 to the asynchronous port; slice p of a wide event field belongs to port p.
- R5: A data write to a waiting-remote entry makes it full. In the same cycle it raises the reply bit of its port with the stored address and the written data.
- R6: A writeback with `wb_clear_i`=1 empties a full entry. It leaves an entry that is not full unchanged. A later asynchronous write fills the cleared entry.
- R7: A read of a full entry returns its data with `rd_valid_o`=1 in the same cycle.
- R8: A read of an entry that receives a data write in the same cycle returns the written data with `rd_valid_o`=1 and records no waiter. A read of an entry cleared in the same cycle returns invalid and suspends the reader.
- R9: When the writeback and an accepted asynchronous write target the same entry in one cycle, the writeback applies and the asynchronous write is applied the next cycle. `aw_ready_o` is low for that next cycle, and an `aw_en_i` presented while `aw_ready_o` is low is ignored.
- R10: `rd_valid_o` is 0 whenever the entry read is not full and receives no data write that cycle. A read of an entry already waiting keeps the first continuation.
- R11: A data write to an empty or full entry raises no wake or reply event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_req_i | input | 1 | Pipeline read request |
| rd_idx_i | input | IDX_W | Entry read |
| rd_remote_i | input | 1 | 1 = remote read, 0 = local thread read |
| rd_tid_i | input | TID_W | Reading thread's table index |
| rd_raddr_i | input | ADDR_W | Remote requester's register address |
| rd_data_o | output | DATA_W | Read data |
| rd_valid_o | output | 1 | Read data valid |
| wb_en_i | input | 1 | Writeback enable |
| wb_idx_i | input | IDX_W | Writeback target |
| wb_clear_i | input | 1 | 1 = set target empty instead of writing data |
| wb_data_i | input | DATA_W | Writeback data |
| aw_en_i | input | 1 | Asynchronous write request |
| aw_idx_i | input | IDX_W | Asynchronous write target |
| aw_data_i | input | DATA_W | Asynchronous write data |
| aw_ready_o | output | 1 | Asynchronous port can accept |
| wake_o | output | 2 | Reschedule event per write port |
| wake_tid_o | output | 2*TID_W | Thread index per write port |
| reply_o | output | 2 | Remote reply event per write port |
| reply_addr_o | output | 2*ADDR_W | Requester address per write port |
| reply_data_o | output | 2*DATA_W | Reply data per write port |

## Verification
The bench targets same-cycle collisions of the following kinds:
- Writeback and asynchronous write on one entry. A design that drops the held write leaves the entry stale; one that applies both loses the writeback value.
- A read with a write on the same entry. Without forwarding, the reader is parked on an entry that is already full and never wakes.
- A clear together with a read. A wrong design both returns data and suspends the reader.

It also checks a second reader on a waiting entry, whose overwrite would wake the wrong thread. It checks writes to empty or full entries, where a spurious event would reschedule a thread twice. Random traffic over a few entries is compared every cycle against a behavioural model.

// File: rtl/sync_rf_pkg.sv
package sync_rf_pkg;
  typedef enum logic [1:0] {
    ST_EMPTY       = 2'd0,
    ST_FULL        = 2'd1,
    ST_WAIT_LOCAL  = 2'd2,
    ST_WAIT_REMOTE = 2'd3
  } reg_state_e;
endpackage

// File: rtl/sync_rf_async_hold.sv
module sync_rf_async_hold #(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              aw_en_i,
  input  logic [IDX_W-1:0]  aw_idx_i,
  input  logic [DATA_W-1:0] aw_data_i,
  input  logic              wb_en_i,
  input  logic [IDX_W-1:0]  wb_idx_i,
  output logic              aw_ready_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic              hold_v_q;
  logic [IDX_W-1:0]  hold_idx_q;
  logic [DATA_W-1:0] hold_data_q;
  logic              src_v, blocked;

  // held write has precedence; new requests are refused while it waits
  assign src_v     = hold_v_q | aw_en_i;
  assign wr_idx_o  = hold_v_q ? hold_idx_q  : aw_idx_i;
  assign wr_data_o = hold_v_q ? hold_data_q : aw_data_i;
  assign blocked   = src_v & wb_en_i & (wb_idx_i == wr_idx_o);
  assign wr_en_o   = src_v & ~blocked;
  assign aw_ready_o = ~hold_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q    <= 1'b0;
      hold_idx_q  <= '0;
      hold_data_q <= '0;
    end else begin
      hold_v_q <= blocked;
      if (blocked) begin
        hold_idx_q  <= wr_idx_o;
        hold_data_q <= wr_data_o;
      end
    end
  end
endmodule

// File: rtl/sync_rf_entry.sv
module sync_rf_entry
  import sync_rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wb_data_hit_i,
  input  logic              wb_clear_hit_i,
  input  logic [DATA_W-1:0] wb_data_i,
  input  logic              aw_hit_i,
  input  logic [DATA_W-1:0] aw_data_i,
  input  logic              rd_hit_i,
  input  logic              rd_remote_i,
  input  logic [DATA_W-1:0] rd_cont_i,
  output reg_state_e        state_o,
  output logic [DATA_W-1:0] data_o
);
  reg_state_e        state_q, state_d, state_clr;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    // clear only affects a full entry
    state_clr = (wb_clear_hit_i && state_q == ST_FULL) ? ST_EMPTY : state_q;
    state_d   = state_clr;
    data_d    = data_q;
    if (wb_data_hit_i) begin
      state_d = ST_FULL;
      data_d  = wb_data_i;
    end else if (aw_hit_i) begin
      state_d = ST_FULL;
      data_d  = aw_data_i;
    end else if (rd_hit_i && state_clr == ST_EMPTY) begin
      state_d = rd_remote_i ? ST_WAIT_REMOTE : ST_WAIT_LOCAL;
      data_d  = rd_cont_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_EMPTY;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      data_q  <= data_d;
    end
  end

  assign state_o = state_q;
  assign data_o  = data_q;
endmodule

// File: rtl/sync_rf_notify.sv
module sync_rf_notify
  import sync_rf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int TID_W    = 6,
  parameter int ADDR_W   = 12,
  parameter int IDX_W    = 5
) (
  input  logic                           wr_en_i,
  input  logic [IDX_W-1:0]               wr_idx_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  input  reg_state_e [NUM_REGS-1:0]      state_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] cont_i,
  output logic                           wake_o,
  output logic [TID_W-1:0]               wake_tid_o,
  output logic                           reply_o,
  output logic [ADDR_W-1:0]              reply_addr_o,
  output logic [DATA_W-1:0]              reply_data_o
);
  localparam int CONT_W = (TID_W > ADDR_W) ? TID_W : ADDR_W;

  reg_state_e        st;
  logic [DATA_W-1:0] cont;
  logic              unused_hi;

  assign st   = state_i[wr_idx_i];
  assign cont = cont_i[wr_idx_i];
  assign unused_hi = ^cont[DATA_W-1:CONT_W];

  assign wake_o       = wr_en_i && (st == ST_WAIT_LOCAL);
  assign wake_tid_o   = cont[TID_W-1:0];
  assign reply_o      = wr_en_i && (st == ST_WAIT_REMOTE);
  assign reply_addr_o = cont[ADDR_W-1:0];
  assign reply_data_o = wr_data_i;
endmodule

// File: rtl/sync_regfile.sv
module sync_regfile
  import sync_rf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int TID_W    = 6,
  parameter int ADDR_W   = 12,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int NPORT   = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rd_req_i,
  input  logic [IDX_W-1:0]         rd_idx_i,
  input  logic                     rd_remote_i,
  input  logic [TID_W-1:0]         rd_tid_i,
  input  logic [ADDR_W-1:0]        rd_raddr_i,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic                     rd_valid_o,
  input  logic                     wb_en_i,
  input  logic [IDX_W-1:0]         wb_idx_i,
  input  logic                     wb_clear_i,
  input  logic [DATA_W-1:0]        wb_data_i,
  input  logic                     aw_en_i,
  input  logic [IDX_W-1:0]         aw_idx_i,
  input  logic [DATA_W-1:0]        aw_data_i,
  output logic                     aw_ready_o,
  output logic [NPORT-1:0]         wake_o,
  output logic [NPORT*TID_W-1:0]   wake_tid_o,
  output logic [NPORT-1:0]         reply_o,
  output logic [NPORT*ADDR_W-1:0]  reply_addr_o,
  output logic [NPORT*DATA_W-1:0]  reply_data_o
);
  reg_state_e [NUM_REGS-1:0]       state_w;
  logic [NUM_REGS-1:0][DATA_W-1:0] data_w;
  logic                            aw_wr_en;
  logic [IDX_W-1:0]                aw_wr_idx;
  logic [DATA_W-1:0]               aw_wr_data;
  logic [DATA_W-1:0]               rd_cont;
  logic [NPORT-1:0]                port_en;
  logic [NPORT-1:0][IDX_W-1:0]     port_idx;
  logic [NPORT-1:0][DATA_W-1:0]    port_data;

  sync_rf_async_hold #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .aw_en_i    (aw_en_i),
    .aw_idx_i   (aw_idx_i),
    .aw_data_i  (aw_data_i),
    .wb_en_i    (wb_en_i),
    .wb_idx_i   (wb_idx_i),
    .aw_ready_o (aw_ready_o),
    .wr_en_o    (aw_wr_en),
    .wr_idx_o   (aw_wr_idx),
    .wr_data_o  (aw_wr_data)
  );

  assign rd_cont = rd_remote_i ? DATA_W'(rd_raddr_i) : DATA_W'(rd_tid_i);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    sync_rf_entry #(.DATA_W(DATA_W)) i_entry (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .wb_data_hit_i  (wb_en_i && !wb_clear_i && wb_idx_i == IDX_W'(g)),
      .wb_clear_hit_i (wb_en_i && wb_clear_i && wb_idx_i == IDX_W'(g)),
      .wb_data_i      (wb_data_i),
      .aw_hit_i       (aw_wr_en && aw_wr_idx == IDX_W'(g)),
      .aw_data_i      (aw_wr_data),
      .rd_hit_i       (rd_req_i && rd_idx_i == IDX_W'(g)),
      .rd_remote_i    (rd_remote_i),
      .rd_cont_i      (rd_cont),
      .state_o        (state_w[g]),
      .data_o         (data_w[g])
    );
  end

  // port 0 = writeback, port 1 = asynchronous
  assign port_en[0]   = wb_en_i && !wb_clear_i;
  assign port_idx[0]  = wb_idx_i;
  assign port_data[0] = wb_data_i;
  assign port_en[1]   = aw_wr_en;
  assign port_idx[1]  = aw_wr_idx;
  assign port_data[1] = aw_wr_data;

  for (genvar p = 0; p < NPORT; p++) begin : g_notify
    sync_rf_notify #(
      .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TID_W(TID_W),
      .ADDR_W(ADDR_W), .IDX_W(IDX_W)
    ) i_notify (
      .wr_en_i      (port_en[p]),
      .wr_idx_i     (port_idx[p]),
      .wr_data_i    (port_data[p]),
      .state_i      (state_w),
      .cont_i       (data_w),
      .wake_o       (wake_o[p]),
      .wake_tid_o   (wake_tid_o[p*TID_W +: TID_W]),
      .reply_o      (reply_o[p]),
      .reply_addr_o (reply_addr_o[p*ADDR_W +: ADDR_W]),
      .reply_data_o (reply_data_o[p*DATA_W +: DATA_W])
    );
  end

  // same-cycle data writes are forwarded; a same-cycle clear hides the entry
  always_comb begin
    rd_valid_o = 1'b0;
    rd_data_o  = data_w[rd_idx_i];
    if (rd_req_i) begin
      if (port_en[0] && wb_idx_i == rd_idx_i) begin
        rd_valid_o = 1'b1;
        rd_data_o  = wb_data_i;
      end else if (aw_wr_en && aw_wr_idx == rd_idx_i) begin
        rd_valid_o = 1'b1;
        rd_data_o  = aw_wr_data;
      end else if (!(wb_en_i && wb_clear_i && wb_idx_i == rd_idx_i)) begin
        rd_valid_o = (state_w[rd_idx_i] == ST_FULL);
      end
    end
  end
endmodule

// File: rtl/sync_regfile_chk.sv
module sync_regfile_chk
  import sync_rf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int TID_W    = 6,
  parameter int IDX_W    = 5
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            rd_req_i,
  input logic [IDX_W-1:0]                rd_idx_i,
  input logic                            rd_remote_i,
  input logic [TID_W-1:0]                rd_tid_i,
  input logic [DATA_W-1:0]               rd_data_o,
  input logic                            rd_valid_o,
  input logic                            wb_en_i,
  input logic [IDX_W-1:0]                wb_idx_i,
  input logic                            aw_en_i,
  input logic [IDX_W-1:0]                aw_idx_i,
  input logic                            aw_ready_o,
  input logic [1:0]                      wake_o,
  input logic [1:0]                      reply_o,
  input logic                            aw_wr_en,
  input logic [IDX_W-1:0]                aw_wr_idx,
  input logic [NUM_REGS-1:0][1:0]        state_i,
  input logic [NUM_REGS-1:0][DATA_W-1:0] data_i
);
  logic rd_no_write;
  assign rd_no_write = !(wb_en_i && wb_idx_i == rd_idx_i) &&
                       !(aw_wr_en && aw_wr_idx == rd_idx_i);

  assert_full_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i && rd_no_write && state_i[rd_idx_i] == ST_FULL
    |-> rd_valid_o && rd_data_o == data_i[rd_idx_i]);

  assert_not_full_invalid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i && rd_no_write && state_i[rd_idx_i] != ST_FULL |-> !rd_valid_o);

  assert_local_suspend_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i && !rd_remote_i && rd_no_write && state_i[rd_idx_i] == ST_EMPTY
    |=> state_i[$past(rd_idx_i)] == ST_WAIT_LOCAL &&
        data_i[$past(rd_idx_i)][TID_W-1:0] == $past(rd_tid_i));

  assert_wb_wake_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o[0] |=> state_i[$past(wb_idx_i)] == ST_FULL);

  assert_aw_wake_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o[1] |=> state_i[$past(aw_wr_idx)] == ST_FULL);

  assert_wb_reply_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reply_o[0] |=> state_i[$past(wb_idx_i)] == ST_FULL);

  assert_aw_reply_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reply_o[1] |=> state_i[$past(aw_wr_idx)] == ST_FULL);

  assert_hold_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aw_en_i && aw_ready_o && wb_en_i && wb_idx_i == aw_idx_i |=> !aw_ready_o);
endmodule

bind sync_regfile sync_regfile_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TID_W(TID_W), .IDX_W(IDX_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_req_i    (rd_req_i),
  .rd_idx_i    (rd_idx_i),
  .rd_remote_i (rd_remote_i),
  .rd_tid_i    (rd_tid_i),
  .rd_data_o   (rd_data_o),
  .rd_valid_o  (rd_valid_o),
  .wb_en_i     (wb_en_i),
  .wb_idx_i    (wb_idx_i),
  .aw_en_i     (aw_en_i),
  .aw_idx_i    (aw_idx_i),
  .aw_ready_o  (aw_ready_o),
  .wake_o      (wake_o),
  .reply_o     (reply_o),
  .aw_wr_en    (aw_wr_en),
  .aw_wr_idx   (aw_wr_idx),
  .state_i     (state_w),
  .data_i      (data_w)
);

// File: tb/test_sync_regfile.sv
`timescale 1ns/1ps
module test_sync_regfile;
  localparam int NR = 32, DW = 32, TW = 6, AW = 12, IW = 5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic rd_req = 0, rd_remote = 0, wb_en = 0, wb_clear = 0, aw_en = 0;
  logic [IW-1:0] rd_idx = '0, wb_idx = '0, aw_idx = '0;
  logic [TW-1:0] rd_tid = '0;
  logic [AW-1:0] rd_raddr = '0;
  logic [DW-1:0] wb_data = '0, aw_data = '0;
  logic [DW-1:0] rd_data_o;
  logic rd_valid_o, aw_ready_o;
  logic [1:0] wake_o, reply_o;
  logic [2*TW-1:0] wake_tid_o;
  logic [2*AW-1:0] reply_addr_o;
  logic [2*DW-1:0] reply_data_o;

  always #2.5 clk = ~clk;

  sync_regfile #(.NUM_REGS(NR), .DATA_W(DW), .TID_W(TW), .ADDR_W(AW)) i_sync_regfile (
    .clk_i(clk), .rst_ni(rst_ni),
    .rd_req_i(rd_req), .rd_idx_i(rd_idx), .rd_remote_i(rd_remote),
    .rd_tid_i(rd_tid), .rd_raddr_i(rd_raddr),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .wb_en_i(wb_en), .wb_idx_i(wb_idx), .wb_clear_i(wb_clear), .wb_data_i(wb_data),
    .aw_en_i(aw_en), .aw_idx_i(aw_idx), .aw_data_i(aw_data), .aw_ready_o(aw_ready_o),
    .wake_o(wake_o), .wake_tid_o(wake_tid_o),
    .reply_o(reply_o), .reply_addr_o(reply_addr_o), .reply_data_o(reply_data_o)
  );

  // reference model: 0 empty, 1 full, 2 waiting local, 3 waiting remote
  int            ms[NR];
  logic [DW-1:0] md[NR];
  bit            cl[NR];
  bit            hold_v;
  int            hold_idx;
  logic [DW-1:0] hold_d;
  int n_checks = 0, n_errors = 0;
  bit in_reset_phase = 0, done = 0;

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic ev_check(int p, bit ew, bit er, logic [DW-1:0] cont, logic [DW-1:0] d);
    string tag;
    tag = ew ? "R4" : (er ? "R5" : "R11");
    chk(wake_o[p] == ew, tag, $sformatf("wake[%0d]", p), 64'(wake_o[p]), 64'(ew));
    chk(reply_o[p] == er, tag, $sformatf("reply[%0d]", p), 64'(reply_o[p]), 64'(er));
    if (ew && wake_o[p])
      chk(wake_tid_o[p*TW +: TW] == cont[TW-1:0], "R4", "wake tid",
          64'(wake_tid_o[p*TW +: TW]), 64'(cont[TW-1:0]));
    if (er && reply_o[p]) begin
      chk(reply_addr_o[p*AW +: AW] == cont[AW-1:0], "R5", "reply addr",
          64'(reply_addr_o[p*AW +: AW]), 64'(cont[AW-1:0]));
      chk(reply_data_o[p*DW +: DW] == d, "R5", "reply data",
          64'(reply_data_o[p*DW +: DW]), 64'(d));
    end
  endtask

  task automatic step_model();
    bit src_v, blocked, ew, wbd, exp_v, datahit;
    int src_idx, s1;
    logic [DW-1:0] src_d, exp_d;
    string tag;
    src_v   = hold_v || aw_en;
    src_idx = hold_v ? hold_idx : int'(aw_idx);
    src_d   = hold_v ? hold_d : aw_data;
    blocked = src_v && wb_en && int'(wb_idx) == src_idx;
    ew      = src_v && !blocked;
    wbd     = wb_en && !wb_clear;

    chk(aw_ready_o == !hold_v, in_reset_phase ? "R1" : "R9", "aw_ready",
        64'(aw_ready_o), 64'(!hold_v));
    ev_check(0, wbd && ms[wb_idx] == 2, wbd && ms[wb_idx] == 3, md[wb_idx], wb_data);
    ev_check(1, ew && ms[src_idx] == 2, ew && ms[src_idx] == 3, md[src_idx], src_d);

    if (rd_req) begin
      exp_v = 0; exp_d = '0;
      if (wbd && wb_idx == rd_idx) begin exp_v = 1; exp_d = wb_data; tag = "R8"; end
      else if (ew && src_idx == int'(rd_idx)) begin exp_v = 1; exp_d = src_d; tag = "R8"; end
      else if (wb_en && wb_clear && wb_idx == rd_idx) tag = "R8";
      else if (ms[rd_idx] == 1) begin exp_v = 1; exp_d = md[rd_idx]; tag = cl[rd_idx] ? "R6" : "R7"; end
      else if (ms[rd_idx] == 0) tag = rd_remote ? "R3" : "R2";
      else tag = "R10";
      if (in_reset_phase) tag = "R1";
      chk(rd_valid_o == exp_v, tag, "rd_valid", 64'(rd_valid_o), 64'(exp_v));
      if (exp_v) chk(rd_data_o == exp_d, tag, "rd_data", 64'(rd_data_o), 64'(exp_d));
    end

    s1 = ms[rd_idx];
    if (wb_en && wb_clear && wb_idx == rd_idx && s1 == 1) s1 = 0;
    datahit = (wbd && wb_idx == rd_idx) || (ew && src_idx == int'(rd_idx));
    if (wb_en) begin
      if (wb_clear) begin
        if (ms[wb_idx] == 1) begin ms[wb_idx] = 0; cl[wb_idx] = 1; end
      end else begin
        ms[wb_idx] = 1; md[wb_idx] = wb_data; cl[wb_idx] = 0;
      end
    end
    if (ew) begin ms[src_idx] = 1; md[src_idx] = src_d; end
    if (rd_req && !datahit && s1 == 0) begin
      ms[rd_idx] = rd_remote ? 3 : 2;
      md[rd_idx] = rd_remote ? DW'(rd_raddr) : DW'(rd_tid);
    end
    hold_v = blocked;
    if (blocked) begin hold_idx = src_idx; hold_d = src_d; end
  endtask

  task automatic cyc();
    #1 step_model();
    @(negedge clk);
  endtask

  task automatic idle();
    rd_req = 0; wb_en = 0; wb_clear = 0; aw_en = 0;
  endtask

  task automatic rd(int i, bit rem, int tid, int ra);
    rd_req = 1; rd_idx = IW'(i); rd_remote = rem; rd_tid = TW'(tid); rd_raddr = AW'(ra);
  endtask

  task automatic wb(int i, bit clr, logic [DW-1:0] d);
    wb_en = 1; wb_idx = IW'(i); wb_clear = clr; wb_data = d;
  endtask

  task automatic aw(int i, logic [DW-1:0] d);
    aw_en = 1; aw_idx = IW'(i); aw_data = d;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) begin ms[i] = 0; md[i] = '0; cl[i] = 0; end
    hold_v = 0; hold_idx = 0; hold_d = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1: reset state seen through the ports
    in_reset_phase = 1;
    idle(); rd(5, 0, 9, 0); cyc();
    idle(); rd(6, 1, 0, 'h44); cyc();
    in_reset_phase = 0;
    idle(); wb(5, 0, 'hAAAA); cyc();               // R4 wake tid 9
    idle(); rd(5, 0, 1, 0); cyc();                  // R7
    idle(); rd(7, 1, 0, 'h123); cyc();              // R3
    idle(); aw(7, 'hBEEF); cyc();                   // R5 reply on port 1
    idle(); wb(6, 0, 'h66); cyc();                  // R5 reply on port 0
    idle(); wb(5, 1, '0); cyc();                    // R6 clear full
    idle(); rd(5, 0, 3, 0); cyc();                  // R2 on cleared entry
    idle(); aw(5, 'h5151); cyc();                   // R6/R4 async fill wakes tid 3
    idle(); rd(5, 0, 2, 0); cyc();                  // R6 read filled
    idle(); wb(9, 0, 'h9090); aw(9, 'h0909); cyc(); // R9 conflict
    idle(); aw(10, 'hDEAD); cyc();                  // R9 ignored, hold applies
    idle(); rd(9, 0, 1, 0); cyc();                  // R9 held data
    idle(); rd(10, 1, 0, 'h11); cyc();              // R9 ignored write left 10 empty
    idle(); wb(12, 0, 'hC0DE); rd(12, 0, 7, 0); cyc(); // R8 forward
    idle(); rd(12, 0, 7, 0); cyc();
    idle(); rd(14, 0, 1, 0); cyc();
    idle(); rd(14, 0, 2, 0); cyc();                 // R10 second waiter
    idle(); wb(14, 0, 'h1414); cyc();               // wake tid 1
    idle(); wb(15, 0, 'h1515); cyc();               // R11 write to empty
    idle(); wb(15, 0, 'h1516); cyc();               // R11 write to full
    idle(); wb(15, 1, '0); rd(15, 0, 4, 0); cyc();  // R8 clear with read
    idle(); wb(15, 0, 'h1517); cyc();               // wake tid 4
    idle(); wb(16, 1, '0); cyc();                   // R6 clear on empty: no effect
    idle(); rd(16, 1, 0, 'h77); cyc();
    idle(); aw(16, 'h1616); cyc();                  // reply 0x77
    for (int n = 0; n < 6000; n++) begin
      idle();
      if ($urandom_range(0, 2) != 0)
        rd($urandom_range(0, 7) == 0 ? $urandom_range(0, NR-1) : $urandom_range(0, 3),
           1'($urandom_range(0, 1)), $urandom_range(0, 63), $urandom_range(0, 4095));
      if ($urandom_range(0, 2) == 0)
        wb($urandom_range(0, 3), $urandom_range(0, 3) == 0, $urandom());
      if ($urandom_range(0, 2) == 0)
        aw($urandom_range(0, 3), $urandom());
      cyc();
    end
    idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule